// File: doc/BRIEF.md
# Log-Domain Binary Arithmetic Decoding Engine

This block decodes one binary symbol per clock cycle from an arithmetic-coded bitstream without any multiplier. The coding interval is held in a split form: a small integer part and an 8-bit fraction for the range, and a 9-bit offset whose top bit is the integer unit above an 8-bit fraction. The probability of the less probable symbol (LPS) is supplied as a 10-bit log-domain value. Its upper eight bits give the LPS share of the range fraction directly, so the sub-range split needs only a subtraction.

Every cycle in which a bin is requested, the engine compares the offset with the most-probable-symbol (MPS) sub-range and decides between MPS and LPS. It returns the bin value and updates its state on the clock edge. An MPS leaves the offset untouched. An LPS renormalises both range and offset. The engine pulls fresh stream bits over three channels, each a window into the stream that starts right after the bits already consumed. The channels are one bit wide, 8 bits wide and 32 bits wide. In the same cycle, the engine reports how many bits it took from each channel, so the external bit reader can advance its pointer. Context storage and stream buffering sit outside the block.

Top module: `lbad_engine`

## Requirements
- R1: After reset the range integer is 0, the range fraction is 255 and the offset is 256. While no bin is being decoded, `out_valid`, `out_bin`, `out_lps` and all three `take_*` counts are 0.
- R2: Let p = `in_prob[9:2]`. The MPS fraction m is (range fraction − p) mod 256, and a borrow is raised when range fraction < p. The MPS boundary is m when there is a borrow and 256 + m otherwise. A bin is LPS exactly when the range integer is 0 and the 9-bit offset is ≥ that boundary.
- R3: When `out_valid` is 1, `out_bin` equals `in_mps` XOR `out_lps`.
- R4: On an MPS the offset keeps its value, the range fraction becomes m, and the range integer increases by `in_bypass`, wrapping at 32.
- R5: On an LPS the range integer becomes 0. The range fraction becomes the low 8 bits of p after p has been doubled until it reaches at least 256. When p is 0 the range fraction becomes 0.
- R6: On an LPS where m ≤ offset[7:0], the seed is offset[7:0] − m and `take_a` is 0.
- R7: On an LPS where m > offset[7:0], `take_a` is 1. The seed is 2·((offset[7:0] − m) mod 256) + `in_bit_a`.
- R8: The seed is doubled, shifting in the next stream bit each time, while it is below 256, up to 40 times. The shifted-in bits come MSB-first from `in_bits_b` and then from `in_bits_c`, and `in_bits_b[7]` is the stream bit that follows any bit taken on `in_bit_a`. For k doublings, `take_b` = min(k, 8) and `take_c` = k − 8 when k > 8, else 0. The result becomes the new offset.
- R9: In a cycle with neither `in_valid` nor `in_load`, the state is unchanged and all `take_*` are 0, whatever bits the channels carry.
- R10: `in_load` sets the range integer to 0, the range fraction to 255 and the offset to `in_load_bits`, whose bit 8 is the first stream bit. It overrides `in_valid`, and `out_valid` is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_load | input | 1 | Start a new stream segment from `in_load_bits` |
| in_load_bits | input | 9 | First nine stream bits, bit 8 first |
| in_valid | input | 1 | Decode one bin this cycle |
| in_prob | input | 10 | Log-domain LPS probability of the context |
| in_mps | input | 1 | Value of the most probable symbol |
| in_bypass | input | 1 | Bin is a bypass bin (MPS adds one to range integer) |
| in_bit_a | input | 1 | One-bit stream channel |
| in_bits_b | input | 8 | Eight-bit stream window, MSB first |
| in_bits_c | input | 32 | Thirty-two-bit stream window, MSB first |
| out_valid | output | 1 | A bin is decoded this cycle |
| out_bin | output | 1 | Decoded bin value |
| out_lps | output | 1 | Decoded bin took the LPS path |
| take_a | output | 1 | Bits consumed from the one-bit channel |
| take_b | output | 4 | Bits consumed from the eight-bit channel |
| take_c | output | 6 | Bits consumed from the thirty-two-bit channel |

## Verification
The bench builds the engine with its default widths: a 5-bit range integer, 8-bit fractions, a 10-bit probability, and 8-bit and 32-bit wide channels. With these widths, a renormalisation that runs through the whole 8-bit window into the 32-bit window can be reached with a short zero run in a bench-controlled stream. So can the 40-doubling cap, reached with an all-zero run of 41 bits. Directed loads reach the borrow path that needs the single-bit channel. Seeded random bins with periodic reloads then mix MPS, LPS, bypass and idle cycles against a bench model that walks the same stream.

// File: rtl/lbad_pkg.sv
package lbad_pkg;
    // default geometry of the decoding engine
    localparam int INT_BITS  = 5;
    localparam int FRAC_BITS = 8;
    localparam int PROB_BITS = 10;
    localparam int MID_BITS  = 8;
    localparam int WIDE_BITS = 32;
endpackage

// File: rtl/lbad_lzc.sv
module lbad_lzc #(
    parameter int W = 8,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] zeros
);
    // count of zero bits above the highest set bit; W when vec is all zero
    always_comb begin
        zeros = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) zeros = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/lbad_range.sv
module lbad_range
    import lbad_pkg::*;
#(
    parameter int FRAC_W = FRAC_BITS,
    parameter int LG_W   = PROB_BITS,
    localparam int ZW    = $clog2(FRAC_W + 1)
) (
    input  logic [FRAC_W-1:0] frac_q,
    input  logic [LG_W-1:0]   prob,
    output logic [FRAC_W-1:0] mps_frac,
    output logic              mps_borrow,
    output logic [FRAC_W-1:0] lps_frac_next
);
    logic [FRAC_W-1:0] lps_share;
    logic [ZW-1:0]     lead;

    // upper bits of the log probability give the LPS part of the fraction
    assign lps_share  = FRAC_W'(prob >> (LG_W - FRAC_W));
    assign mps_borrow = frac_q < lps_share;
    // modulo arithmetic folds in the +256 of the borrow case
    assign mps_frac   = frac_q - lps_share;

    lbad_lzc #(.W(FRAC_W)) u_lead (
        .vec  (lps_share),
        .zeros(lead)
    );

    // doubling until bit FRAC_W is set, then dropping that bit
    assign lps_frac_next = (lps_share << lead) << 1;
endmodule

// File: rtl/lbad_offset.sv
module lbad_offset
    import lbad_pkg::*;
#(
    parameter int FRAC_W = FRAC_BITS,
    parameter int MID_W  = MID_BITS,
    parameter int WIDE_W = WIDE_BITS,
    localparam int XW    = FRAC_W + 1 + MID_W + WIDE_W,
    localparam int KMAX  = MID_W + WIDE_W,
    localparam int ZW    = $clog2(XW + 1),
    localparam int BW    = $clog2(MID_W + 1),
    localparam int CW    = $clog2(WIDE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lps_en,
    input  logic [FRAC_W:0]   ofs_q,
    input  logic [FRAC_W-1:0] mps_frac,
    input  logic              bit_a,
    input  logic [MID_W-1:0]  bits_b,
    input  logic [WIDE_W-1:0] bits_c,
    output logic [FRAC_W:0]   ofs_lps,
    output logic              take_a,
    output logic [BW-1:0]     take_b,
    output logic [CW-1:0]     take_c
);
    logic              direct;
    logic [FRAC_W-1:0] diff;
    logic [FRAC_W:0]   seed;
    logic [XW-1:0]     win;
    logic [XW-1:0]     win_sh;
    logic [ZW-1:0]     lead;
    logic [ZW-1:0]     shift;

    assign direct = mps_frac <= ofs_q[FRAC_W-1:0];
    assign diff   = ofs_q[FRAC_W-1:0] - mps_frac;
    assign seed   = direct ? {1'b0, diff} : {diff, bit_a};
    assign win    = {seed, bits_b, bits_c};

    lbad_lzc #(.W(XW)) u_lead (
        .vec  (win),
        .zeros(lead)
    );

    assign shift   = (lead > ZW'(KMAX)) ? ZW'(KMAX) : lead;
    assign win_sh  = win << shift;
    assign ofs_lps = (FRAC_W + 1)'(win_sh >> (XW - FRAC_W - 1));

    always_comb begin
        take_a = lps_en & ~direct;
        take_b = '0;
        take_c = '0;
        if (lps_en) begin
            if (shift > ZW'(MID_W)) begin
                take_b = BW'(MID_W);
                take_c = CW'(shift - ZW'(MID_W));
            end else begin
                take_b = BW'(shift);
            end
        end
    end

    // R8
    wide_after_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_c != '0) |-> (take_b == BW'(MID_W)));
    // R8
    renorm_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lps_en && take_c < CW'(WIDE_W)) |-> ofs_lps[FRAC_W]);
    // R7
    single_bit_lps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_a |-> lps_en);
endmodule

// File: rtl/lbad_engine.sv
module lbad_engine
    import lbad_pkg::*;
#(
    parameter int INT_W  = INT_BITS,
    parameter int FRAC_W = FRAC_BITS,
    parameter int LG_W   = PROB_BITS,
    parameter int MID_W  = MID_BITS,
    parameter int WIDE_W = WIDE_BITS,
    localparam int BW    = $clog2(MID_W + 1),
    localparam int CW    = $clog2(WIDE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_load,
    input  logic [FRAC_W:0]   in_load_bits,
    input  logic              in_valid,
    input  logic [LG_W-1:0]   in_prob,
    input  logic              in_mps,
    input  logic              in_bypass,
    input  logic              in_bit_a,
    input  logic [MID_W-1:0]  in_bits_b,
    input  logic [WIDE_W-1:0] in_bits_c,
    output logic              out_valid,
    output logic              out_bin,
    output logic              out_lps,
    output logic              take_a,
    output logic [BW-1:0]     take_b,
    output logic [CW-1:0]     take_c
);
    typedef struct packed {
        logic [INT_W-1:0]  ri;
        logic [FRAC_W-1:0] rf;
        logic [FRAC_W:0]   of;
    } eng_state_t;

    eng_state_t st_d, st_q;

    logic [FRAC_W-1:0] mps_frac;
    logic              mps_borrow;
    logic [FRAC_W-1:0] lps_frac_next;
    logic [FRAC_W:0]   ofs_lps;
    logic [FRAC_W:0]   boundary;
    logic              is_lps;
    logic              go;

    lbad_range #(.FRAC_W(FRAC_W), .LG_W(LG_W)) u_range (
        .frac_q       (st_q.rf),
        .prob         (in_prob),
        .mps_frac     (mps_frac),
        .mps_borrow   (mps_borrow),
        .lps_frac_next(lps_frac_next)
    );

    lbad_offset #(.FRAC_W(FRAC_W), .MID_W(MID_W), .WIDE_W(WIDE_W)) u_offset (
        .clk     (clk),
        .rst_n   (rst_n),
        .lps_en  (out_lps),
        .ofs_q   (st_q.of),
        .mps_frac(mps_frac),
        .bit_a   (in_bit_a),
        .bits_b  (in_bits_b),
        .bits_c  (in_bits_c),
        .ofs_lps (ofs_lps),
        .take_a  (take_a),
        .take_b  (take_b),
        .take_c  (take_c)
    );

    always_comb begin
        go        = in_valid & ~in_load;
        boundary  = mps_borrow ? {1'b0, mps_frac} : {1'b1, mps_frac};
        is_lps    = (st_q.ri == '0) && (st_q.of >= boundary);
        out_valid = go;
        out_lps   = go & is_lps;
        out_bin   = go & (in_mps ^ is_lps);

        st_d = st_q;
        if (in_load) begin
            st_d.ri = '0;
            st_d.rf = '1;
            st_d.of = in_load_bits;
        end else if (in_valid) begin
            if (is_lps) begin
                st_d.ri = '0;
                st_d.rf = lps_frac_next;
                st_d.of = ofs_lps;
            end else begin
                st_d.ri = st_q.ri + INT_W'(in_bypass);
                st_d.rf = mps_frac;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ri <= '0;
            st_q.rf <= '1;
            st_q.of <= (FRAC_W + 1)'(1) << FRAC_W;
        end else begin
            st_q <= st_d;
        end
    end

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !in_load) |=> $stable(st_q));
    // R9
    idle_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!take_a && take_b == '0 && take_c == '0));
    // R4
    mps_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_lps) |=> $stable(st_q.of));
    // R5
    lps_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_lps |=> (st_q.ri == '0));
    // R10
    load_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_load |=> (st_q.ri == '0 && st_q.rf == '1 && st_q.of == $past(in_load_bits)));
endmodule

// File: tb/sim_lbad_engine.sv
module sim_lbad_engine;
    localparam int CLK_NS = 10;
    localparam int SLEN   = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_load = 1'b0;
    logic [8:0]  in_load_bits = '0;
    logic        in_valid = 1'b0;
    logic [9:0]  in_prob = '0;
    logic        in_mps = 1'b0;
    logic        in_bypass = 1'b0;
    logic        in_bit_a = 1'b0;
    logic [7:0]  in_bits_b = '0;
    logic [31:0] in_bits_c = '0;
    logic        out_valid, out_bin, out_lps, take_a;
    logic [3:0]  take_b;
    logic [5:0]  take_c;

    always #(CLK_NS / 2) clk = ~clk;

    lbad_engine u0 (
        .clk(clk), .rst_n(rst_n), .in_load(in_load), .in_load_bits(in_load_bits),
        .in_valid(in_valid), .in_prob(in_prob), .in_mps(in_mps), .in_bypass(in_bypass),
        .in_bit_a(in_bit_a), .in_bits_b(in_bits_b), .in_bits_c(in_bits_c),
        .out_valid(out_valid), .out_bin(out_bin), .out_lps(out_lps),
        .take_a(take_a), .take_b(take_b), .take_c(take_c)
    );

    int errs = 0;
    int checks = 0;
    bit finished = 1'b0;
    bit strm [0:SLEN-1];
    int ptr = 0;
    int m_ri = 0;
    int m_rf = 255;
    int m_of = 256;

    function automatic bit sb(int i);
        return strm[i % SLEN];
    endfunction

    task automatic putv(int val, int n);
        for (int i = 0; i < n; i++) strm[(ptr + i) % SLEN] = bit'((val >> (n - 1 - i)) & 1);
    endtask

    task automatic cmp(string req, string what, string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s %s (%s): got %0d expected %0d", req, what, tag, got, exp);
        end
    endtask

    task automatic step(string tag, bit v, bit ld, int lg, bit mps, bit byp);
        int lsh, rfm, mark, f, t, k, n1, q, r;
        int nri, nrf, nof, e_bin, e_lps, e_val;
        bit lps;
        @(negedge clk);
        nri = m_ri; nrf = m_rf; nof = m_of;
        e_bin = 0; e_lps = 0; e_val = 0; n1 = 0; k = 0; q = ptr;
        if (ld) begin
            nof = 0;
            for (int i = 0; i < 9; i++) nof = (nof << 1) | int'(sb(ptr + i));
            nri = 0; nrf = 255; q = ptr + 9;
        end else if (v) begin
            e_val = 1;
            lsh = (lg >> 2) & 255;
            rfm = (m_rf - lsh) & 255;
            mark = (m_rf < lsh) ? rfm : 256 + rfm;
            lps = (m_ri == 0) && (m_of >= mark);
            e_lps = int'(lps);
            e_bin = int'(mps ^ lps);
            if (!lps) begin
                nri = (m_ri + int'(byp)) % 32;
                nrf = rfm;
            end else begin
                nri = 0;
                r = lsh;
                if (r == 0) nrf = 0;
                else begin
                    while (r < 256) r = r << 1;
                    nrf = r & 255;
                end
                f = m_of & 255;
                if (rfm <= f) t = f - rfm;
                else begin
                    t = ((256 + f - rfm) << 1) | int'(sb(q));
                    n1 = 1;
                    q++;
                end
                while (t < 256 && k < 40) begin
                    t = (t << 1) | int'(sb(q));
                    q++;
                    k++;
                end
                nof = t;
            end
        end
        in_load = ld; in_valid = v; in_prob = 10'(lg); in_mps = mps; in_bypass = byp;
        for (int i = 0; i < 9; i++) in_load_bits[8 - i] = sb(ptr + i);
        in_bit_a = sb(ptr);
        for (int i = 0; i < 8; i++) in_bits_b[7 - i] = sb(ptr + n1 + i);
        for (int i = 0; i < 32; i++) in_bits_c[31 - i] = sb(ptr + n1 + 8 + i);
        #1;
        cmp("R9", "out_valid", tag, 32'(out_valid), 32'(e_val));
        cmp("R2", "out_lps", tag, 32'(out_lps), 32'(e_lps));
        cmp("R3", "out_bin", tag, 32'(out_bin), 32'(e_bin));
        cmp("R7", "take_a", tag, 32'(take_a), 32'(n1));
        cmp("R8", "take_b", tag, 32'(take_b), 32'(k > 8 ? 8 : k));
        cmp("R8", "take_c", tag, 32'(take_c), 32'(k > 8 ? k - 8 : 0));
        @(posedge clk);
        m_ri = nri; m_rf = nrf; m_of = nof; ptr = q;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL R9 watchdog: got running expected finished");
        summary();
    end

    initial begin
        int seed_v;
        seed_v = int'($urandom(32'd915));
        for (int i = 0; i < SLEN; i++) strm[i] = bit'($urandom % 2);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, idle outputs, then a bin seen against the reset state
        step("R1", 0, 0, 0, 0, 0);
        step("R1", 1, 0, 0, 1, 0);
        // R10: load wins over a simultaneous bin request
        putv(9'h1FF, 9);
        step("R10", 1, 1, 1020, 0, 0);
        // R5: LPS with the largest share
        step("R5", 1, 0, 1020, 0, 0);
        // R6 then R7: direct subtract, then the borrow path using the one-bit channel
        putv(9'h1FF, 9);
        step("R10", 0, 1, 0, 0, 0);
        step("R6", 1, 0, 512, 1, 0);
        step("R7", 1, 0, 4, 1, 0);
        // R8: zero seed, run reaching into the wide channel
        putv(9'h1BF, 9);
        step("R10", 0, 1, 0, 0, 0);
        for (int i = 0; i < 20; i++) strm[(ptr + i) % SLEN] = 1'b0;
        strm[(ptr + 20) % SLEN] = 1'b1;
        step("R8", 1, 0, 256, 0, 0);
        // R8: all-zero run hits the 40-doubling cap
        putv(9'h1BF, 9);
        step("R10", 0, 1, 0, 0, 0);
        for (int i = 0; i < 41; i++) strm[(ptr + i) % SLEN] = 1'b0;
        step("R8", 1, 0, 256, 0, 0);
        // R9: idle cycle with busy channels, then a bin that depends on held state
        step("R9", 0, 0, 1020, 1, 1);
        step("R9", 1, 0, 700, 1, 0);
        // R4: bypass MPS raises the integer part and blocks the following LPS
        putv(9'h100, 9);
        step("R10", 0, 1, 0, 0, 0);
        step("R4", 1, 0, 0, 0, 1);
        step("R4", 1, 0, 1020, 0, 0);
        // seeded random mix with periodic reloads
        for (int n = 0; n < 1500; n++) begin
            bit ld, v, byp;
            ld  = (n % 25) == 0;
            v   = ($urandom % 5) != 0;
            byp = ($urandom % 10) == 0;
            step("rand", v, ld, int'($urandom % 1024), bit'($urandom % 2), byp);
        end
        summary();
    end
endmodule